// File: doc/BRIEF.md
# Serial Management Register Slave

This block is the device side of a two-wire serial management port. It runs on the management clock. Each rising edge samples the bidirectional data line, and the block decodes read and write frames sent by a single bus controller. A frame counts only when a long run of ones comes first. That run is followed by a start pattern, an opcode, a device address, a register address, a turnaround and a 16-bit data field. The device address in the frame must equal the value on five strap inputs, so several devices can share one bus.

The block holds a bank of thirty-two 16-bit registers. Only the registers named in a parameter mask are built. On a read, the block drives the selected register back onto the line through an output-enable. On a write, it stores the data field. A disable input shuts out all management traffic. One bit of register 26 is brought out as a pin that selects stronger output drive on the data interface.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset, every register reads 0x0000, `mdio_oe` is low and `hi_drive` is low.
- R2: A start pattern is accepted only after at least 32 consecutive ones have been sampled. With fewer ones, the frame that follows is ignored: there is no drive and no register change. After every frame, a fresh run of 32 ones is needed again.
- R3: After the run of ones, the start field must be 0 then 1. The opcode is 1,0 for read and 0,1 for write. Any other start or opcode abandons the frame: there is no drive, no write, and the block goes back to hunting for the run of ones.
- R4: After the opcode come a 5-bit device address and a 5-bit register address, each sent most significant bit first. The block acts only when the device address equals `strap_addr`.
- R5: On an accepted read, `mdio_oe` stays low during the first turnaround bit period. During the second turnaround period it is high with `mdio_o` = 0. In the next 16 periods it carries D15 first, down to D0. It is low again in the period right after D0.
- R6: On an accepted write, the two turnaround bits are ignored. The next 16 bits, MSB first, are stored into the addressed register at the edge that samples D0.
- R7: Registers outside the implemented set read 0x0000, and writes to them have no effect. The default implemented set is registers 0–7 and 16–26, so registers 8–15 and 27–31 are unimplemented.
- R8: While `mgmt_disable` is high, `mdio_oe` stays low and no write takes effect. When it is low, reads and writes both work.
- R9: `hi_drive` always equals bit 11 of register 26.
- R10: The value returned by a read is the register content captured in the first turnaround period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; every action happens on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdio_i | input | 1 | Sampled value of the shared data line |
| mdio_o | output | 1 | Value this block drives onto the data line |
| mdio_oe | output | 1 | Output enable for `mdio_o`; low means released |
| strap_addr | input | 5 | Strapped device address |
| mgmt_disable | input | 1 | High blocks all reads and writes |
| hi_drive | output | 1 | Register 26 bit 11: selects higher drive strength |

## Verification
Matched-address reads and writes of random data to random registers check the field decode and the exact turnaround and data timing. They also check that data round-trips through the bank. Frames with a foreign address, with the disable input high, with a short preamble, or with an illegal start or opcode must leave both the line and the registers untouched. In each case, a later read from the same register tells a silent drop apart from a stray write. Writes to unimplemented registers, and writes that set and then clear bit 11 of register 26, separate the built registers from the missing ones and confirm the drive-strength pin follows its bit.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 16;
    localparam int REG_NUM = 1 << ADDR_W;
    localparam int PRE_LEN = 32;
    localparam int ONES_W  = $clog2(PRE_LEN + 1);
    localparam int CNT_W   = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_OPCODE,
        ST_PHYAD,
        ST_REGAD,
        ST_TURN,
        ST_DATA
    } frame_state_e;

    typedef struct packed {
        frame_state_e              state;
        logic [ONES_W-1:0]         ones;
        logic [CNT_W-1:0]          cnt;
        logic                      opc;
        logic                      is_read;
        logic [ADDR_W-1:0]         phy;
        logic                      mine;
        logic [ADDR_W-1:0]         regad;
        logic                      active;
        logic [DATA_W-1:0]         shreg;
        logic                      oe;
        logic                      dout;
    } frame_regs_t;

endpackage

// File: rtl/mdio_regbank.sv
module mdio_regbank
    import mdio_slave_pkg::*;
#(
    parameter logic [REG_NUM-1:0] IMPL_MASK = 32'h07FF_00FF,
    parameter int                 CTL_REG   = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ctl_word
);

    logic [REG_NUM-1:0][DATA_W-1:0] bank_d, bank_q;
    logic [REG_NUM-1:0][DATA_W-1:0] view;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && IMPL_MASK[wr_addr]) begin
            bank_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    for (genvar i = 0; i < REG_NUM; i++) begin : g_view
        if (IMPL_MASK[i]) begin : g_built
            assign view[i] = bank_q[i];
        end else begin : g_absent
            assign view[i] = '0;
        end
    end

    assign rd_data  = view[rd_addr];
    assign ctl_word = view[CTL_REG];

    // R6: an accepted write to a built register holds the written word next cycle
    a_r6_write_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && IMPL_MASK[wr_addr]) |=> (bank_q[$past(wr_addr)] == $past(wr_data)));

    // R7: a missing register keeps reading zero even right after a write to it
    a_r7_absent_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !IMPL_MASK[wr_addr]) |=> (view[$past(wr_addr)] == '0));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_slave_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_i,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              mgmt_disable,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              drv_oe,
    output logic              drv_o
);

    frame_regs_t q, d;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_data = {q.shreg[DATA_W-2:0], mdio_i};
        unique case (q.state)
            ST_HUNT: begin
                d.oe   = 1'b0;
                d.dout = 1'b0;
                if (mdio_i) begin
                    if (q.ones != ONES_W'(PRE_LEN)) d.ones = q.ones + 1'b1;
                end else if (q.ones == ONES_W'(PRE_LEN)) begin
                    d.ones  = '0;
                    d.state = ST_START;
                end else begin
                    d.ones = '0;
                end
            end
            ST_START: begin
                d.cnt   = '0;
                d.state = mdio_i ? ST_OPCODE : ST_HUNT;
            end
            ST_OPCODE: begin
                if (q.cnt == '0) begin
                    d.opc = mdio_i;
                    d.cnt = CNT_W'(1);
                end else begin
                    d.cnt = '0;
                    if (q.opc && !mdio_i) begin
                        d.is_read = 1'b1;
                        d.state   = ST_PHYAD;
                    end else if (!q.opc && mdio_i) begin
                        d.is_read = 1'b0;
                        d.state   = ST_PHYAD;
                    end else begin
                        d.state = ST_HUNT;
                    end
                end
            end
            ST_PHYAD: begin
                d.phy = {q.phy[ADDR_W-2:0], mdio_i};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(ADDR_W-1)) begin
                    d.cnt   = '0;
                    d.mine  = ({q.phy[ADDR_W-2:0], mdio_i} == strap_addr);
                    d.state = ST_REGAD;
                end
            end
            ST_REGAD: begin
                d.regad = {q.regad[ADDR_W-2:0], mdio_i};
                d.cnt   = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(ADDR_W-1)) begin
                    d.cnt    = '0;
                    d.active = q.mine && !mgmt_disable;
                    d.state  = ST_TURN;
                end
            end
            ST_TURN: begin
                if (q.cnt == '0) begin
                    d.cnt = CNT_W'(1);
                    if (q.active && q.is_read) begin
                        d.oe    = 1'b1;
                        d.dout  = 1'b0;
                        d.shreg = rd_data;
                    end
                end else begin
                    d.cnt   = '0;
                    d.state = ST_DATA;
                    if (q.active && q.is_read) begin
                        d.dout  = q.shreg[DATA_W-1];
                        d.shreg = {q.shreg[DATA_W-2:0], 1'b0};
                    end
                end
            end
            ST_DATA: begin
                d.cnt = q.cnt + 1'b1;
                if (q.is_read) begin
                    if (q.cnt != CNT_W'(DATA_W-1)) begin
                        d.dout  = q.shreg[DATA_W-1];
                        d.shreg = {q.shreg[DATA_W-2:0], 1'b0};
                    end else begin
                        d.oe   = 1'b0;
                        d.dout = 1'b0;
                    end
                end else begin
                    d.shreg = {q.shreg[DATA_W-2:0], mdio_i};
                    if (q.cnt == CNT_W'(DATA_W-1) && q.active && !mgmt_disable) begin
                        wr_en = 1'b1;
                    end
                end
                if (q.cnt == CNT_W'(DATA_W-1)) begin
                    d.cnt    = '0;
                    d.active = 1'b0;
                    d.ones   = '0;
                    d.state  = ST_HUNT;
                end
            end
            default: d.state = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_HUNT;
        end else begin
            q <= d;
        end
    end

    assign reg_addr = q.regad;
    assign drv_oe   = q.oe;
    assign drv_o    = q.dout;

    // R2: no start is taken before the run of ones is complete
    a_r2_start_needs_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_HUNT && q.ones != ONES_W'(PRE_LEN)) |=> (q.state != ST_START));

    // R3: a repeated opcode bit abandons the frame
    a_r3_bad_opcode_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_OPCODE && q.cnt != '0 && q.opc == mdio_i) |=> (q.state == ST_HUNT));

    // R5: the first driven bit is the turnaround zero
    a_r5_turn_drives_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> (q.dout == 1'b0 && q.state == ST_TURN));

    // R5: releasing the line always ends the frame
    a_r5_release_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.oe) |-> (q.state == ST_HUNT));

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
    import mdio_slave_pkg::*;
#(
    parameter logic [REG_NUM-1:0] IMPL_MASK = 32'h07FF_00FF,
    parameter int                 CTL_REG   = 26,
    parameter int                 CTL_BIT   = 11
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              mgmt_disable,
    output logic              hi_drive
);

    logic [ADDR_W-1:0] reg_addr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] ctl_word;
    logic              drv_oe;
    logic              drv_o;

    mdio_frame_fsm u_fsm (
        .clk          (mdc),
        .rst_n        (rst_n),
        .mdio_i       (mdio_i),
        .strap_addr   (strap_addr),
        .mgmt_disable (mgmt_disable),
        .rd_data      (rd_data),
        .reg_addr     (reg_addr),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .drv_oe       (drv_oe),
        .drv_o        (drv_o)
    );

    mdio_regbank #(
        .IMPL_MASK (IMPL_MASK),
        .CTL_REG   (CTL_REG)
    ) u_bank (
        .clk      (mdc),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (reg_addr),
        .wr_data  (wr_data),
        .rd_addr  (reg_addr),
        .rd_data  (rd_data),
        .ctl_word (ctl_word)
    );

    assign mdio_oe  = drv_oe & ~mgmt_disable;
    assign mdio_o   = drv_o & mdio_oe;
    assign hi_drive = ctl_word[CTL_BIT];

    // R9: the drive-strength pin moves only after a write to its register
    a_r9_pin_follows_write: assert property (@(posedge mdc) disable iff (!rst_n)
        !$stable(hi_drive) |-> $past(wr_en && reg_addr == ADDR_W'(CTL_REG)));

    // R8: a write never lands while the disable input is high
    a_r8_no_write_when_off: assert property (@(posedge mdc) disable iff (!rst_n)
        mgmt_disable |=> $stable(ctl_word));

endmodule

// File: tb/mdio_mgmt_slave_test.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_test;

    localparam logic [31:0] MASK = 32'h07FF_00FF;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n;
    logic       host_drv;
    logic       host_val;
    logic       dis;
    logic [4:0] strap;
    logic       mdio_o, mdio_oe, hi;
    logic       bus;

    assign bus = mdio_oe ? mdio_o : (host_drv ? host_val : 1'b1);

    mdio_mgmt_slave uut (
        .mdc          (clk),
        .rst_n        (rst_n),
        .mdio_i       (bus),
        .mdio_o       (mdio_o),
        .mdio_oe      (mdio_oe),
        .strap_addr   (strap),
        .mgmt_disable (dis),
        .hi_drive     (hi)
    );

    int checks = 0;
    int fails  = 0;
    logic [15:0] model [32];

    function automatic logic [15:0] expect_rd(input logic [4:0] ra);
        return MASK[ra] ? model[ra] : 16'h0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input bit b);
        @(negedge clk);
        host_drv = 1'b1;
        host_val = b;
    endtask

    task automatic header(input int pre, input logic [1:0] st, input logic [1:0] op,
                          input logic [4:0] phy, input logic [4:0] ra);
        if (pre < 32) begin
            put(1'b0);
            put(1'b0);
        end
        repeat (pre) put(1'b1);
        put(st[1]); put(st[0]);
        put(op[1]); put(op[0]);
        for (int i = 4; i >= 0; i--) put(phy[i]);
        for (int i = 4; i >= 0; i--) put(ra[i]);
    endtask

    task automatic do_write(input int pre, input logic [1:0] st, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] ra,
                            input logic [15:0] data);
        header(pre, st, op, phy, ra);
        put(1'b1); put(1'b0);
        for (int i = 15; i >= 0; i--) put(data[i]);
        put(1'b1);
        if (pre >= 32 && st == 2'b01 && op == 2'b01 && phy == strap && !dis && MASK[ra])
            model[ra] = data;
        chk(hi == model[26][11], "R9", "hi_drive after write", hi, model[26][11]);
    endtask

    task automatic do_read(input int pre, input logic [4:0] phy, input logic [4:0] ra,
                           input bit resp, input string req);
        logic [15:0] got;
        logic [15:0] exp;
        bit oe_ok;
        exp = expect_rd(ra);
        header(pre, 2'b01, 2'b10, phy, ra);
        @(negedge clk);
        host_drv = 1'b0;
        chk(mdio_oe == 1'b0, "R5", "oe in first turnaround", mdio_oe, 0);
        @(negedge clk);
        if (resp)
            chk(mdio_oe && !mdio_o, "R5", "second turnaround drives 0",
                {mdio_oe, mdio_o}, 2);
        else
            chk(!mdio_oe, req, "no drive in turnaround", mdio_oe, 0);
        got   = '0;
        oe_ok = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            got[i] = mdio_o;
            if (mdio_oe != resp) oe_ok = 1'b0;
        end
        chk(oe_ok, resp ? "R5" : req, "oe during data", oe_ok, 1);
        if (resp) chk(got == exp, req, "read data", got, exp);
        @(negedge clk);
        chk(mdio_oe == 1'b0, "R5", "release after D0", mdio_oe, 0);
        host_drv = 1'b1;
        host_val = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [4:0]  phy, ra;
        logic [15:0] data;
        void'($urandom(32'd4711));
        for (int i = 0; i < 32; i++) model[i] = '0;
        rst_n    = 1'b0;
        host_drv = 1'b0;
        host_val = 1'b1;
        dis      = 1'b0;
        strap    = 5'h0B;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mdio_oe == 1'b0, "R1", "oe after reset", mdio_oe, 0);
        chk(hi == 1'b0, "R1", "hi_drive after reset", hi, 0);
        do_read(32, strap, 5'd26, 1'b1, "R1");
        do_read(32, strap, 5'd3, 1'b1, "R1");

        // R6 basic write and read back
        do_write(32, 2'b01, 2'b01, strap, 5'd3, 16'h1234);
        do_read(32, strap, 5'd3, 1'b1, "R6");
        do_write(32, 2'b01, 2'b01, strap, 5'd20, 16'h8001);
        do_read(32, strap, 5'd20, 1'b1, "R10");

        // R9 drive-strength bit set then cleared
        do_write(32, 2'b01, 2'b01, strap, 5'd26, 16'h0800);
        chk(hi == 1'b1, "R9", "hi_drive set", hi, 1);
        do_write(32, 2'b01, 2'b01, strap, 5'd26, 16'hF7FF);
        chk(hi == 1'b0, "R9", "hi_drive cleared", hi, 0);

        // R7 unimplemented registers
        do_write(32, 2'b01, 2'b01, strap, 5'd31, 16'hABCD);
        do_read(32, strap, 5'd31, 1'b1, "R7");
        do_write(32, 2'b01, 2'b01, strap, 5'd10, 16'h5A5A);
        do_read(32, strap, 5'd10, 1'b1, "R7");

        // R3 illegal opcode and start
        do_write(32, 2'b01, 2'b11, strap, 5'd3, 16'hFFFF);
        do_read(32, strap, 5'd3, 1'b1, "R3");
        do_write(32, 2'b01, 2'b00, strap, 5'd3, 16'h0F0F);
        do_read(32, strap, 5'd3, 1'b1, "R3");
        do_write(32, 2'b00, 2'b01, strap, 5'd3, 16'h0000);
        do_read(32, strap, 5'd3, 1'b1, "R3");

        // R2 short preamble
        do_write(31, 2'b01, 2'b01, strap, 5'd4, 16'hBEEF);
        do_read(32, strap, 5'd4, 1'b1, "R2");
        do_read(31, strap, 5'd3, 1'b0, "R2");

        // R4 foreign address
        do_write(32, 2'b01, 2'b01, 5'h0A, 5'd3, 16'hCAFE);
        do_read(32, 5'h0A, 5'd3, 1'b0, "R4");
        do_read(32, strap, 5'd3, 1'b1, "R4");

        // R8 disabled access
        dis = 1'b1;
        do_write(32, 2'b01, 2'b01, strap, 5'd5, 16'h7777);
        do_read(32, strap, 5'd5, 1'b0, "R8");
        dis = 1'b0;
        do_read(32, strap, 5'd5, 1'b1, "R8");

        // R4 other strap value
        strap = 5'h1F;
        do_write(32, 2'b01, 2'b01, 5'h1F, 5'd0, 16'h00FF);
        do_read(32, 5'h1F, 5'd0, 1'b1, "R4");

        // random mix
        for (int n = 0; n < 60; n++) begin
            phy  = ($urandom % 4 == 0) ? 5'($urandom) : strap;
            ra   = 5'($urandom);
            data = 16'($urandom);
            dis  = ($urandom % 7 == 0);
            if ($urandom % 2 == 0)
                do_write(32, 2'b01, 2'b01, phy, ra, data);
            else
                do_read(32, phy, ra, (phy == strap) && !dis, "R6");
            dis = 1'b0;
        end
        for (int r = 0; r < 32; r++) begin
            if (r % 3 == 0) do_read(32, strap, 5'(r), 1'b1, "R7");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule